// File: doc/BRIEF.md
# Epoch-Tagged Fetch Redirect Controller

This block holds the control state that lets two pipeline stages, decode and execute, steer the fetch PC without ever acting on an instruction from a cancelled path. Every redirecting stage owns a one-bit epoch that flips each time that stage issues a redirect. Fetch keeps its own copy of each epoch and stamps every instruction it issues with both copies. Decode and execute compare the stamps against their own epochs and decide whether each arriving instruction is kept or poisoned. Poisoned instructions still travel down the pipeline so that later bookkeeping, such as scoreboard release, can retire them, but they must change no architectural state.

Redirect requests from decode and execute wait in one-entry slots in front of fetch. An execute request always wins. A decode request is honoured only if the execute-epoch stamp it carries still matches fetch's copy; otherwise execute has already cancelled that path and the request is thrown away. In any cycle where fetch handles a request, it issues nothing.

The predictors, the datapath and the register file sit outside the block. The surrounding pipeline supplies the next-address guess, decode's direction-based target and execute's resolved target.

Top module: `redirect_epoch_ctrl`

## Requirements
- R1: After reset the fetch PC equals the START_PC parameter, both epoch stamps on the fetch side read 0, no redirect is pending, and neither decode nor execute reports keep or poison while its valid input is low.
- R2: With no redirect pending and f_ready_i high, f_fire_o is high and the PC takes f_pred_pc_i on the next edge. With f_ready_i low and nothing pending, nothing issues and the PC holds.
- R3: A pending execute redirect is handled first, even when a decode redirect is also pending. In that cycle the PC is loaded with the resolved target on the next edge and f_etag_o flips.
- R4: A pending decode redirect, once no execute redirect is pending, is always consumed. If its carried execute stamp equals f_etag_o, the PC is loaded with decode's target and f_dtag_o flips. Otherwise the PC and f_dtag_o are left unchanged.
- R5: f_fire_o is low in every cycle in which fetch handles a pending redirect.
- R6: A valid decode instruction whose execute stamp differs from decode's execute-epoch copy is kept. Decode then takes that stamp as its copy and the instruction's decode stamp as its own epoch.
- R7: Otherwise a valid decode instruction whose decode stamp differs from decode's epoch is poisoned. For every valid decode instruction exactly one of d_keep_o and d_poison_o is high.
- R8: A kept decode instruction whose d_ppc_i differs from d_dir_pc_i flips decode's epoch and raises a redirect to d_dir_pc_i that carries the instruction's execute stamp.
- R9: A valid execute instruction whose stamp differs from the execute epoch is poisoned, otherwise it is kept. A kept instruction with e_mispred_i high flips the execute epoch and raises a redirect to e_target_i.
- R10: The instructions kept at execute form exactly the correct program path, in order, starting at START_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_ready_i | input | 1 | Downstream can take a fetched instruction this cycle |
| f_pred_pc_i | input | PC_W | Next-address guess for the current fetch PC |
| f_pc_o | output | PC_W | Current fetch PC |
| f_fire_o | output | 1 | An instruction is issued at f_pc_o this cycle |
| f_etag_o | output | 1 | Execute-epoch stamp for the issued instruction |
| f_dtag_o | output | 1 | Decode-epoch stamp for the issued instruction |
| d_valid_i | input | 1 | Decode holds an instruction |
| d_etag_i | input | 1 | Execute stamp of the decode instruction |
| d_dtag_i | input | 1 | Decode stamp of the decode instruction |
| d_ppc_i | input | PC_W | Next PC fetch assumed for the decode instruction |
| d_dir_pc_i | input | PC_W | Next PC decode's direction predictor gives |
| d_keep_o | output | 1 | Decode instruction is on the live path |
| d_poison_o | output | 1 | Decode instruction is on a cancelled path |
| e_valid_i | input | 1 | Execute holds an instruction |
| e_etag_i | input | 1 | Execute stamp of the execute instruction |
| e_mispred_i | input | 1 | Execute resolved a next PC different from the predicted one |
| e_target_i | input | PC_W | Resolved next PC |
| e_keep_o | output | 1 | Execute instruction may update state |
| e_poison_o | output | 1 | Execute instruction must not update state |

## Verification
The assertions watch every cycle for the fetch arbitration rules: no issue while a request is pending, execute first, stale decode requests dropped without moving the PC or the decode stamp, and the decode stamp changing only when a decode request is consumed. They also check that keep and poison are exclusive at both stages and that every mispredict lands in a request slot. Whether the kept stream matches the real program path can only be shown by the bench's scenarios. These scenarios cover straight-line code, decode-corrected branches, execute-corrected branches, and a branch whose wrong-path successor raises a decode redirect in the same cycle as the execute redirect. They run both with and without fetch stalls and score each kept instruction against a reference walk of the program.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  typedef enum logic [2:0] {
    FA_IDLE,
    FA_ISSUE,
    FA_EXEC,
    FA_DEC_TAKE,
    FA_DEC_DROP
  } fetch_act_e;

  // a stamp is current when it equals the holder's epoch
  function automatic logic tag_fresh(input logic carried, input logic held);
    return carried == held;
  endfunction

  // fetch arbitration: execute first, then decode (filtered), then issue
  function automatic fetch_act_e pick_fetch_act(input logic ex_pend,
                                                input logic dec_pend,
                                                input logic dec_fresh,
                                                input logic ready);
    if (ex_pend)       return FA_EXEC;
    else if (dec_pend) return dec_fresh ? FA_DEC_TAKE : FA_DEC_DROP;
    else if (ready)    return FA_ISSUE;
    else               return FA_IDLE;
  endfunction

endpackage

// File: rtl/rdc_fetch.sv
module rdc_fetch
  import rdc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] START_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ready_i,
  input  logic [PC_W-1:0] pred_pc_i,
  input  logic            ex_req_i,
  input  logic [PC_W-1:0] ex_pc_i,
  input  logic            dec_req_i,
  input  logic [PC_W-1:0] dec_pc_i,
  input  logic            dec_tag_i,
  output logic [PC_W-1:0] pc_o,
  output logic            fire_o,
  output logic            etag_o,
  output logic            dtag_o,
  output fetch_act_e      act_o,
  output logic            ex_pend_o,
  output logic [PC_W-1:0] ex_pc_o,
  output logic            dec_pend_o,
  output logic            dec_tag_o
);

  logic [PC_W-1:0] pc_q, ex_pc_q, dec_pc_q;
  logic            fe_ep_q, fd_ep_q;
  logic            ex_pend_q, dec_pend_q, dec_tag_q;
  fetch_act_e      act;

  always_comb act = pick_fetch_act(ex_pend_q, dec_pend_q,
                                   tag_fresh(dec_tag_q, fe_ep_q), ready_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q       <= START_PC;
      fe_ep_q    <= 1'b0;
      fd_ep_q    <= 1'b0;
      ex_pend_q  <= 1'b0;
      ex_pc_q    <= '0;
      dec_pend_q <= 1'b0;
      dec_pc_q   <= '0;
      dec_tag_q  <= 1'b0;
    end else begin
      unique case (act)
        FA_EXEC: begin
          pc_q    <= ex_pc_q;
          fe_ep_q <= ~fe_ep_q;
        end
        FA_DEC_TAKE: begin
          pc_q    <= dec_pc_q;
          fd_ep_q <= ~fd_ep_q;
        end
        FA_ISSUE: pc_q <= pred_pc_i;
        default: ;
      endcase
      if (act == FA_EXEC) ex_pend_q <= 1'b0;
      if (ex_req_i) begin
        ex_pend_q <= 1'b1;
        ex_pc_q   <= ex_pc_i;
      end
      if (act == FA_DEC_TAKE || act == FA_DEC_DROP) dec_pend_q <= 1'b0;
      if (dec_req_i) begin
        dec_pend_q <= 1'b1;
        dec_pc_q   <= dec_pc_i;
        dec_tag_q  <= dec_tag_i;
      end
    end
  end

  assign pc_o       = pc_q;
  assign fire_o     = (act == FA_ISSUE);
  assign etag_o     = fe_ep_q;
  assign dtag_o     = fd_ep_q;
  assign act_o      = act;
  assign ex_pend_o  = ex_pend_q;
  assign ex_pc_o    = ex_pc_q;
  assign dec_pend_o = dec_pend_q;
  assign dec_tag_o  = dec_tag_q;

endmodule

// File: rtl/rdc_decode.sv
module rdc_decode
  import rdc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic            etag_i,
  input  logic            dtag_i,
  input  logic [PC_W-1:0] ppc_i,
  input  logic [PC_W-1:0] dir_pc_i,
  output logic            keep_o,
  output logic            poison_o,
  output logic            redir_o,
  output logic [PC_W-1:0] redir_pc_o,
  output logic            redir_tag_o,
  output logic            de_ep_o
);

  logic de_ep_q, d_ep_q;
  logic new_path, keep, mis;

  always_comb begin
    new_path = !tag_fresh(etag_i, de_ep_q);
    keep     = valid_i && (new_path || tag_fresh(dtag_i, d_ep_q));
    mis      = keep && (ppc_i != dir_pc_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_ep_q <= 1'b0;
      d_ep_q  <= 1'b0;
    end else if (valid_i && new_path) begin
      de_ep_q <= etag_i;
      d_ep_q  <= dtag_i ^ mis;
    end else if (mis) begin
      d_ep_q <= ~d_ep_q;
    end
  end

  assign keep_o      = keep;
  assign poison_o    = valid_i && !keep;
  assign redir_o     = mis;
  assign redir_pc_o  = dir_pc_i;
  assign redir_tag_o = etag_i;
  assign de_ep_o     = de_ep_q;

endmodule

// File: rtl/rdc_exec.sv
module rdc_exec
  import rdc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic            etag_i,
  input  logic            mispred_i,
  input  logic [PC_W-1:0] target_i,
  output logic            keep_o,
  output logic            poison_o,
  output logic            redir_o,
  output logic [PC_W-1:0] redir_pc_o
);

  logic e_ep_q, keep;

  always_comb keep = valid_i && tag_fresh(etag_i, e_ep_q);

  always_ff @(posedge clk) begin
    if (!rst_n)                  e_ep_q <= 1'b0;
    else if (keep && mispred_i)  e_ep_q <= ~e_ep_q;
  end

  assign keep_o     = keep;
  assign poison_o   = valid_i && !keep;
  assign redir_o    = keep && mispred_i;
  assign redir_pc_o = target_i;

endmodule

// File: rtl/redirect_epoch_ctrl.sv
module redirect_epoch_ctrl
  import rdc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] START_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            f_ready_i,
  input  logic [PC_W-1:0] f_pred_pc_i,
  output logic [PC_W-1:0] f_pc_o,
  output logic            f_fire_o,
  output logic            f_etag_o,
  output logic            f_dtag_o,
  input  logic            d_valid_i,
  input  logic            d_etag_i,
  input  logic            d_dtag_i,
  input  logic [PC_W-1:0] d_ppc_i,
  input  logic [PC_W-1:0] d_dir_pc_i,
  output logic            d_keep_o,
  output logic            d_poison_o,
  input  logic            e_valid_i,
  input  logic            e_etag_i,
  input  logic            e_mispred_i,
  input  logic [PC_W-1:0] e_target_i,
  output logic            e_keep_o,
  output logic            e_poison_o
);

  // named internal events, used by the bound checker
  logic            dec_redir, dec_redir_tag, de_ep;
  logic [PC_W-1:0] dec_redir_pc;
  logic            ex_redir;
  logic [PC_W-1:0] ex_redir_pc;
  logic            ex_pend, dec_pend, dec_tag_q;
  logic [PC_W-1:0] ex_pc_q;
  fetch_act_e      fetch_act;

  rdc_fetch #(.PC_W(PC_W), .START_PC(START_PC)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (f_ready_i),
    .pred_pc_i  (f_pred_pc_i),
    .ex_req_i   (ex_redir),
    .ex_pc_i    (ex_redir_pc),
    .dec_req_i  (dec_redir),
    .dec_pc_i   (dec_redir_pc),
    .dec_tag_i  (dec_redir_tag),
    .pc_o       (f_pc_o),
    .fire_o     (f_fire_o),
    .etag_o     (f_etag_o),
    .dtag_o     (f_dtag_o),
    .act_o      (fetch_act),
    .ex_pend_o  (ex_pend),
    .ex_pc_o    (ex_pc_q),
    .dec_pend_o (dec_pend),
    .dec_tag_o  (dec_tag_q)
  );

  rdc_decode #(.PC_W(PC_W)) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (d_valid_i),
    .etag_i      (d_etag_i),
    .dtag_i      (d_dtag_i),
    .ppc_i       (d_ppc_i),
    .dir_pc_i    (d_dir_pc_i),
    .keep_o      (d_keep_o),
    .poison_o    (d_poison_o),
    .redir_o     (dec_redir),
    .redir_pc_o  (dec_redir_pc),
    .redir_tag_o (dec_redir_tag),
    .de_ep_o     (de_ep)
  );

  rdc_exec #(.PC_W(PC_W)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (e_valid_i),
    .etag_i     (e_etag_i),
    .mispred_i  (e_mispred_i),
    .target_i   (e_target_i),
    .keep_o     (e_keep_o),
    .poison_o   (e_poison_o),
    .redir_o    (ex_redir),
    .redir_pc_o (ex_redir_pc)
  );

endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            f_fire,
  input logic [PC_W-1:0] f_pc,
  input logic            f_etag,
  input logic            f_dtag,
  input logic            ex_pend,
  input logic [PC_W-1:0] ex_pc,
  input logic            dec_pend,
  input logic            dec_tag,
  input logic            dec_redir,
  input logic            ex_redir,
  input logic            d_valid,
  input logic            d_etag,
  input logic            d_keep,
  input logic            d_poison,
  input logic            de_ep,
  input logic            e_valid,
  input logic            e_keep,
  input logic            e_poison
);

  a_r5_no_issue_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_pend || dec_pend) |-> !f_fire);

  a_r3_exec_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ex_pend |=> (f_pc == $past(ex_pc)) && (f_etag != $past(f_etag)));

  a_r4_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_pend && !ex_pend && (dec_tag != f_etag))
      |=> ($stable(f_pc) && $stable(f_dtag) && !dec_pend));

  a_r4_fresh_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_pend && !ex_pend && (dec_tag == f_etag)) |=> (f_dtag != $past(f_dtag)));

  a_r4_dtag_moves_only_on_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (f_dtag != $past(f_dtag)) |-> $past(dec_pend && !ex_pend));

  a_r6_adopt_new_etag: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && (d_etag != de_ep)) |=> (de_ep == $past(d_etag)));

  a_r7_decode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({d_keep, d_poison}) == (d_valid ? 1 : 0));

  a_r8_decode_request_queued: assert property (@(posedge clk) disable iff (!rst_n)
    dec_redir |=> dec_pend);

  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    dec_redir |-> !dec_pend);

  a_r9_exec_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({e_keep, e_poison}) == (e_valid ? 1 : 0));

  a_r9_exec_request_queued: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redir |=> ex_pend);

endmodule

bind redirect_epoch_ctrl rdc_checker #(.PC_W(PC_W)) u_rdc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .f_fire    (f_fire_o),
  .f_pc      (f_pc_o),
  .f_etag    (f_etag_o),
  .f_dtag    (f_dtag_o),
  .ex_pend   (ex_pend),
  .ex_pc     (ex_pc_q),
  .dec_pend  (dec_pend),
  .dec_tag   (dec_tag_q),
  .dec_redir (dec_redir),
  .ex_redir  (ex_redir),
  .d_valid   (d_valid_i),
  .d_etag    (d_etag_i),
  .d_keep    (d_keep_o),
  .d_poison  (d_poison_o),
  .de_ep     (de_ep),
  .e_valid   (e_valid_i),
  .e_keep    (e_keep_o),
  .e_poison  (e_poison_o)
);

// File: tb/tb_redirect_epoch_ctrl.sv
`timescale 1ns/1ps
module tb_redirect_epoch_ctrl;

  localparam int          PC_W  = 32;
  localparam logic [31:0] START = 32'h0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f_ready_i = 1'b0;
  logic [31:0] f_pred_pc_i;
  logic [31:0] f_pc_o;
  logic        f_fire_o, f_etag_o, f_dtag_o;
  logic        d_valid_i = 1'b0, d_etag_i = 1'b0, d_dtag_i = 1'b0;
  logic [31:0] d_ppc_i = '0, d_dir_pc_i = '0;
  logic        d_keep_o, d_poison_o;
  logic        e_valid_i = 1'b0, e_etag_i = 1'b0, e_mispred_i = 1'b0;
  logic [31:0] e_target_i = '0;
  logic        e_keep_o, e_poison_o;

  always #4 clk = ~clk;  // 125 MHz

  assign f_pred_pc_i = f_pc_o + 32'd4;  // fetch guesses fall-through

  redirect_epoch_ctrl #(.PC_W(PC_W), .START_PC(START)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // program: resolved next PC and decode's direction guess, per word slot
  logic [31:0] act_tbl [64];
  logic [31:0] dp_tbl  [64];
  logic [31:0] exp_q [$];

  function automatic logic [31:0] actual_nx(input logic [31:0] pc);
    return act_tbl[pc[7:2]];
  endfunction
  function automatic logic [31:0] dpred_nx(input logic [31:0] pc);
    return dp_tbl[pc[7:2]];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic load_prog(input int id);
    for (int i = 0; i < 64; i++) begin
      act_tbl[i] = (i + 1) * 4;
      dp_tbl[i]  = (i + 1) * 4;
    end
    case (id)
      1: begin  // decode corrects fetch
        act_tbl[5] = 40; dp_tbl[5] = 40;
        act_tbl[12] = 8; dp_tbl[12] = 8;
      end
      2: begin  // execute corrects decode
        act_tbl[5] = 40; dp_tbl[5] = 24;
        act_tbl[12] = 8; dp_tbl[12] = 8;
      end
      3: begin  // stale decode redirect behind an execute redirect
        act_tbl[5] = 40; dp_tbl[5] = 24;
        dp_tbl[6] = 100;
        act_tbl[11] = 48; dp_tbl[11] = 60;
        act_tbl[12] = 8; dp_tbl[12] = 8;
      end
      default: ;
    endcase
  endtask

  // driver: push the correct path into the scoreboard queue
  task automatic push_path(input int n);
    logic [31:0] p;
    exp_q.delete();
    p = START;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(p);
      p = actual_nx(p);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    d_valid_i = 1'b0; e_valid_i = 1'b0; f_ready_i = 1'b0; e_mispred_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(f_pc_o == START, "R1 pc", f_pc_o, START);
    check(f_etag_o == 1'b0, "R1 etag", {31'b0, f_etag_o}, 0);
    check(f_dtag_o == 1'b0, "R1 dtag", {31'b0, f_dtag_o}, 0);
    check(!d_keep_o && !d_poison_o && !e_keep_o && !e_poison_o, "R1 idle decisions",
          {28'b0, d_keep_o, d_poison_o, e_keep_o, e_poison_o}, 0);
  endtask

  task automatic run(input int id, input int nkept, input bit stall);
    logic        dv = 0, det = 0, ddt = 0, ev = 0, eet = 0, emark = 0;
    logic [31:0] dpc = 0, dppc = 0, epc = 0, eppc = 0;
    int          dmark = 0;
    logic        pend_e = 0, pend_d = 0, pend_d_tag = 0, first_after_ex = 0;
    logic [31:0] pend_e_pc = 0, pend_d_pc = 0;
    logic        exp_pc_v = 0, exp_et_v = 0, exp_dt_v = 0, exp_et = 0, exp_dt = 0;
    logic [31:0] exp_pc = 0;
    string       exp_tag = "R2";
    int          kept = 0;
    logic        exr, der;
    logic [31:0] exr_pc;
    load_prog(id);
    push_path(nkept);
    do_reset();
    for (int cyc = 0; cyc < 4000 && kept < nkept; cyc++) begin
      if (cyc != 0) @(negedge clk);
      f_ready_i   = (stall && (cyc % 5 == 3)) ? 1'b0 : 1'b1;
      d_valid_i   = dv; d_etag_i = det; d_dtag_i = ddt;
      d_ppc_i     = dppc; d_dir_pc_i = dpred_nx(dpc);
      e_valid_i   = ev; e_etag_i = eet;
      e_mispred_i = ev && (actual_nx(epc) != eppc);
      e_target_i  = actual_nx(epc);
      #1;
      if (exp_pc_v) check(f_pc_o == exp_pc, exp_tag, f_pc_o, exp_pc);
      if (exp_et_v) check(f_etag_o == exp_et, "R3 etag flip", {31'b0, f_etag_o}, {31'b0, exp_et});
      if (exp_dt_v) check(f_dtag_o == exp_dt, "R4 dtag", {31'b0, f_dtag_o}, {31'b0, exp_dt});
      exp_pc_v = 0; exp_et_v = 0; exp_dt_v = 0;
      // fetch side
      if (pend_e) begin
        check(!f_fire_o, "R5 exec handling", {31'b0, f_fire_o}, 0);
        exp_pc = pend_e_pc; exp_pc_v = 1; exp_tag = "R3 pc";
        exp_et = ~f_etag_o; exp_et_v = 1;
        pend_e = 0; first_after_ex = 1;
      end else if (pend_d) begin
        check(!f_fire_o, "R5 decode handling", {31'b0, f_fire_o}, 0);
        if (pend_d_tag == f_etag_o) begin
          exp_pc = pend_d_pc; exp_dt = ~f_dtag_o; exp_tag = "R8 taken pc";
        end else begin
          exp_pc = f_pc_o; exp_dt = f_dtag_o; exp_tag = "R4 stale pc";
        end
        exp_pc_v = 1; exp_dt_v = 1; pend_d = 0;
      end else if (f_ready_i) begin
        check(f_fire_o, "R2 issue", {31'b0, f_fire_o}, 1);
        exp_pc = f_pc_o + 4; exp_pc_v = 1; exp_tag = "R2 advance";
      end else begin
        check(!f_fire_o, "R2 stall", {31'b0, f_fire_o}, 0);
        exp_pc = f_pc_o; exp_pc_v = 1; exp_tag = "R2 hold";
      end
      // execute side / commit monitor
      exr = 0; exr_pc = '0;
      if (ev) begin
        if (emark) check(e_poison_o, "R9 poison stale", {31'b0, e_poison_o}, 1);
        if (e_keep_o) begin
          if (exp_q.size() == 0) check(0, "R10 extra kept", epc, 0);
          else begin
            logic [31:0] want;
            want = exp_q.pop_front();
            check(epc == want, "R10 path", epc, want);
          end
          kept++;
          if (e_mispred_i) begin exr = 1; exr_pc = actual_nx(epc); end
        end
      end
      // decode side
      der = 0;
      if (dv) begin
        if (dmark == 1) check(d_keep_o, "R6 adopt keep", {31'b0, d_keep_o}, 1);
        if (dmark == 2) check(d_poison_o, "R7 poison", {31'b0, d_poison_o}, 1);
        der = d_keep_o && (dpred_nx(dpc) != dppc);
      end
      // advance bench pipeline
      emark = exr && dv && d_keep_o;
      ev = dv && d_keep_o; epc = dpc; eppc = dpred_nx(dpc); eet = det;
      dmark = der ? 2 : (first_after_ex ? 1 : 0);
      dv = f_fire_o; dpc = f_pc_o; dppc = f_pc_o + 4; det = f_etag_o; ddt = f_dtag_o;
      if (f_fire_o) first_after_ex = 0;
      if (exr) begin pend_e = 1; pend_e_pc = exr_pc; end
      if (der) begin pend_d = 1; pend_d_pc = dpred_nx(dpc == f_pc_o && dv ? d_ppc_i : d_ppc_i); end
      if (der) begin pend_d_pc = d_dir_pc_i; pend_d_tag = d_etag_i; end
    end
    check(kept >= nkept, "R10 kept count", kept, nkept);
  endtask

  initial begin
    run(0, 20, 1'b0);
    run(1, 30, 1'b0);
    run(2, 30, 1'b0);
    run(3, 40, 1'b0);
    run(3, 40, 1'b1);
    run(1, 30, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10: watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule